// File: doc/BRIEF.md
# Shared Address/Data Bus Port Front End

This block is the clocked front end of one port of a 16K-word by 16-bit memory whose address and data travel on the same 16-bit bus. On each rising clock edge it looks at chip select, the address strobe, the read/write select, the output enable, one enable per byte lane, and a sleep request. When a strobe is accepted, it registers the 14-bit address from the bus, together with the access direction and the lane enables. It then runs the data phase: for a write, it picks up the data one cycle later, and for a read, it drives the data two cycles later.

Toward the memory array, the block gives a word address, a write strobe for each lane, write data and a read request. The array has one cycle of read latency, and its registered output comes back on `mem_rdata`. Toward the bus, the block gives the outgoing word and one drive enable per lane. Those enables control the tristate buffers of the pads. Sleep works without the clock: it silences the bus and the memory at once and stops any access from starting.

Top module: `mux_port_ctrl`

## Requirements
- R1: An address is taken from `bus_in[13:0]` only at a rising edge where `cs_n`=0, `strb_n`=0, `sleep`=0 and at least one lane is enabled. In the following cycle, `mem_addr` presents that address. A strobe edge with `strb_n`=1 starts nothing.
- R2: For a write (`wr_n`=0 at the strobe edge), `mem_we` is active in the cycle after the strobe, and `mem_wdata` carries the data on `bus_in` in that cycle. `mem_we[1]` covers bits 15:8, and `mem_we[0]` covers bits 7:0. A lane is enabled when its bit of `lane_n` is 0 (`lane_n[1]` = upper, `lane_n[0]` = lower).
- R3: For a read (`wr_n`=1 at the strobe edge), the block sends `mem_re` in the cycle after the strobe. If `oe_n` is 0 at the next edge, then two cycles after the strobe `bus_oe` equals the enabled lanes, and `bus_out` carries the stored word on those lanes.
- R4: A strobe with both bits of `lane_n` at 1 produces no write, no read and no drive.
- R5: A strobe with `cs_n`=1 produces no write, no read and no drive.
- R6: If `oe_n` is 1 at the edge after a read strobe, the memory read still takes place, but `bus_oe` stays 0.
- R7: While `sleep`=1, `bus_oe`, `mem_we` and `mem_re` are 0 with no clock edge needed, and any strobe is ignored.
- R8: The direction and lane enables used for an access are the values present at its strobe edge. Changes to them in later cycles have no effect.
- R9: Read strobes on two consecutive edges each deliver their own word, in order, on two consecutive cycles.
- R10: While `rst_n` is 0, `bus_oe`, `mem_we` and `mem_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request, acts without the clock |
| cs_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Address strobe, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| oe_n | input | 1 | Output enable, active low |
| lane_n | input | 2 | Byte lane enables, active low, bit 1 = upper |
| bus_in | input | 16 | Value seen on the shared bus |
| bus_out | output | 16 | Word to drive onto the shared bus |
| bus_oe | output | 2 | Per-lane pad drive enable |
| mem_addr | output | 14 | Word address to the array |
| mem_we | output | 2 | Per-lane write strobe to the array |
| mem_wdata | output | 16 | Write data to the array |
| mem_re | output | 1 | Read request to the array |
| mem_rdata | input | 16 | Array read data, one cycle after `mem_re` |

## Verification
The properties assume that the host never strobes in the data cycle of a write, and never strobes in a cycle in which the block drives the bus. They also assume that all inputs have known values after reset. The stimulus keeps to these rules. It runs one access at a time with an idle cycle between accesses. The only overlapping case it uses is a pair of reads whose strobes fall on adjacent edges, followed by idle cycles while the data comes back.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic {
    ACC_WR = 1'b0,
    ACC_RD = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/mpc_rst_sync.sv
module mpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mpc_addr_stage.sv
module mpc_addr_stage
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              s1_valid,
  output acc_kind_e         s1_kind,
  output logic [LANES-1:0]  s1_lane,
  output logic [ADDR_W-1:0] s1_addr
);
  logic              take;
  logic              valid_d;
  acc_kind_e         kind_d;
  logic [LANES-1:0]  lane_d;
  logic [ADDR_W-1:0] addr_d;

  // accept a strobe only when selected, awake and at least one lane on
  always_comb begin
    take    = !sleep && !cs_n && !strb_n && (lane_n != {LANES{1'b1}});
    valid_d = take;
    kind_d  = take ? acc_kind_e'(wr_n) : s1_kind;
    lane_d  = take ? ~lane_n : s1_lane;
    addr_d  = take ? bus_addr : s1_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_kind  <= ACC_WR;
      s1_lane  <= '0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= valid_d;
      s1_kind  <= kind_d;
      s1_lane  <= lane_d;
      s1_addr  <= addr_d;
    end
  end
endmodule

// File: rtl/mpc_drive_stage.sv
module mpc_drive_stage
  import mpc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             oe_n,
  input  logic             s1_valid,
  input  acc_kind_e        s1_kind,
  input  logic [LANES-1:0] s1_lane,
  output logic [LANES-1:0] drv_q
);
  logic [LANES-1:0] drv_d;

  always_comb begin
    if (s1_valid && (s1_kind == ACC_RD) && !oe_n && !sleep) drv_d = s1_lane;
    else                                                   drv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= '0;
    else        drv_q <= drv_d;
  end
endmodule

// File: rtl/mux_port_ctrl.sv
module mux_port_ctrl
  import mpc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 14,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [LANES-1:0]  bus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              rst_n_i;
  logic              s1_valid;
  acc_kind_e         s1_kind;
  logic [LANES-1:0]  s1_lane;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  drv_q;

  mpc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_i)
  );

  mpc_addr_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) addr_stage_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .sleep    (sleep),
    .cs_n     (cs_n),
    .strb_n   (strb_n),
    .wr_n     (wr_n),
    .lane_n   (lane_n),
    .bus_addr (bus_in[ADDR_W-1:0]),
    .s1_valid (s1_valid),
    .s1_kind  (s1_kind),
    .s1_lane  (s1_lane),
    .s1_addr  (s1_addr)
  );

  mpc_drive_stage #(.LANES(LANES)) drive_stage_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .s1_valid (s1_valid),
    .s1_kind  (s1_kind),
    .s1_lane  (s1_lane),
    .drv_q    (drv_q)
  );

  assign mem_addr  = s1_addr;
  assign mem_wdata = bus_in;
  assign mem_re    = s1_valid && (s1_kind == ACC_RD) && !sleep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_we[g] = s1_valid && (s1_kind == ACC_WR) && s1_lane[g] && !sleep;
    assign bus_oe[g] = drv_q[g] && !sleep;
    assign bus_out[g*LANE_W +: LANE_W] =
      bus_oe[g] ? mem_rdata[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/mpc_port_chk.sv
module mpc_port_chk #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 14,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              cs_n,
  input logic              strb_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [LANES-1:0]  lane_n,
  input logic [LANES-1:0]  bus_oe,
  input logic [LANES-1:0]  mem_we,
  input logic              mem_re
);
  p_we_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> $past(!cs_n && !strb_n && !wr_n && !sleep));

  p_we_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> (mem_we == ~$past(lane_n)));

  p_drive_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe != '0) |-> ($past(!oe_n) && $past(!cs_n && !strb_n && wr_n, 2)
                        && (bus_oe == ~$past(lane_n, 2))));

  p_no_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !strb_n && (&lane_n)) |=> (mem_we == '0 && !mem_re));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (mem_we == '0 && !mem_re));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && oe_n) |=> (bus_oe == '0));

  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (bus_oe == '0 && mem_we == '0 && !mem_re));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (bus_oe == '0 && mem_we == '0 && !mem_re));
endmodule

bind mux_port_ctrl mpc_port_chk #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .strb_n(strb_n),
  .wr_n(wr_n), .oe_n(oe_n), .lane_n(lane_n), .bus_oe(bus_oe),
  .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/mux_port_ctrl_tb_top.sv
module mux_port_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sleep;
  logic        cs_n, strb_n, wr_n, oe_n;
  logic [1:0]  lane_n;
  logic [15:0] bus_in;
  logic [15:0] bus_out;
  logic [1:0]  bus_oe;
  logic [13:0] mem_addr;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata;
  logic        mem_re;
  logic [15:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] arr_mem [int];
  logic [15:0] ref_mem [int];

  mux_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .strb_n(strb_n),
    .wr_n(wr_n), .oe_n(oe_n), .lane_n(lane_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // simple synchronous array with one cycle read latency
  always @(posedge clk) begin
    logic [15:0] w;
    int a;
    a = int'(mem_addr);
    w = arr_mem.exists(a) ? arr_mem[a] : 16'h0000;
    if (mem_we[1]) w[15:8] = mem_wdata[15:8];
    if (mem_we[0]) w[7:0]  = mem_wdata[7:0];
    if (|mem_we) arr_mem[a] = w;
    if (mem_re) mem_rdata <= w;
  end

  function automatic logic [15:0] ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; strb_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
    lane_n = 2'b11; bus_in = 16'h0000;
  endtask

  // lanes: bit1 upper, bit0 lower, 1 = enabled
  task automatic do_write(input logic [13:0] a, input logic [15:0] d,
                          input logic [1:0] lanes, input bit sel);
    logic [1:0]  exp_we;
    logic [15:0] w;
    @(negedge clk);
    cs_n = !sel; strb_n = 1'b0; wr_n = 1'b0; lane_n = ~lanes; bus_in = {2'b00, a};
    @(negedge clk);
    cs_n = 1'b1; strb_n = 1'b1; wr_n = 1'b1; lane_n = lanes; bus_in = d; // R8 scramble
    #1;
    exp_we = sel ? lanes : 2'b00;
    check(sel ? "R2" : "R5", 32'(mem_we), 32'(exp_we));
    if (exp_we != 2'b00) check("R1", 32'(mem_addr), 32'(a));
    if (exp_we != 2'b00) begin
      w = ref_get(int'(a));
      w = (w & ~lane_mask(exp_we)) | (d & lane_mask(exp_we));
      ref_mem[int'(a)] = w;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input logic [13:0] a, input logic [1:0] lanes,
                         input bit sel, input bit oe, input string req);
    logic [1:0] exp_oe;
    bit live;
    live = sel && (lanes != 2'b00);
    @(negedge clk);
    cs_n = !sel; strb_n = 1'b0; wr_n = 1'b1; lane_n = ~lanes; bus_in = {2'b00, a};
    @(negedge clk);
    cs_n = 1'b1; strb_n = 1'b1; wr_n = 1'b0; lane_n = lanes; oe_n = !oe; bus_in = 16'h0;
    #1;
    check(req, 32'(mem_re), 32'(live));
    @(negedge clk);
    idle();
    #1;
    exp_oe = (live && oe) ? lanes : 2'b00;
    check(req, 32'(bus_oe), 32'(exp_oe));
    check(req, 32'(bus_out & lane_mask(exp_oe)),
          32'(ref_get(int'(a)) & lane_mask(exp_oe)));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] addrs [8];
    rst_n = 1'b1; sleep = 1'b0; idle();
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R10", 32'({bus_oe, mem_we, mem_re}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", 32'({bus_oe, mem_we, mem_re}), 32'd0);

    // sweep addresses and all lane combinations
    for (int i = 0; i < 8; i++) begin
      addrs[i] = 14'((i * 5461 + 3) & 16'h3FFF);
      do_write(addrs[i], 16'hA5C3 ^ 16'(i * 4369), 2'b11, 1'b1);
      do_read(addrs[i], 2'b11, 1'b1, 1'b1, "R3");
      for (int ln = 0; ln < 4; ln++) begin
        do_write(addrs[i], 16'(i * 777 + ln * 12345), 2'(ln), 1'b1);
        do_read(addrs[i], 2'b11, 1'b1, 1'b1, ln == 0 ? "R4" : "R2");
        do_read(addrs[i], 2'(ln), 1'b1, 1'b1, ln == 0 ? "R4" : "R3");
      end
    end

    // deselected write and read
    do_write(addrs[0], 16'hDEAD, 2'b11, 1'b0);
    do_read(addrs[0], 2'b11, 1'b1, 1'b1, "R5");
    do_read(addrs[0], 2'b11, 1'b0, 1'b1, "R5");

    // output enable off
    do_read(addrs[1], 2'b11, 1'b1, 1'b0, "R6");
    do_read(addrs[1], 2'b01, 1'b1, 1'b0, "R6");

    // strobe high with select low: nothing starts
    @(negedge clk);
    cs_n = 1'b0; strb_n = 1'b1; wr_n = 1'b0; lane_n = 2'b00; bus_in = 16'h0100;
    @(negedge clk);
    idle(); #1;
    check("R1", 32'({mem_we, mem_re}), 32'd0);

    // sleep during strobe blocks the write
    @(negedge clk);
    sleep = 1'b1; cs_n = 1'b0; strb_n = 1'b0; wr_n = 1'b0; lane_n = 2'b00;
    bus_in = {2'b00, addrs[2]};
    @(negedge clk);
    sleep = 1'b0; idle(); bus_in = 16'h5555; #1;
    check("R7", 32'(mem_we), 32'd0);
    @(negedge clk);
    do_read(addrs[2], 2'b11, 1'b1, 1'b1, "R7");

    // sleep silences an active drive without a clock edge
    @(negedge clk);
    cs_n = 1'b0; strb_n = 1'b0; wr_n = 1'b1; lane_n = 2'b00; bus_in = {2'b00, addrs[3]};
    @(negedge clk);
    idle(); oe_n = 1'b0;
    @(negedge clk);
    idle(); #1;
    check("R3", 32'(bus_oe), 32'd3);
    sleep = 1'b1; #1;
    check("R7", 32'({bus_oe, mem_we, mem_re}), 32'd0);
    sleep = 1'b0; #1;
    check("R7", 32'(bus_oe), 32'd3);
    check("R7", 32'(bus_out), 32'(ref_get(int'(addrs[3]))));
    @(negedge clk);

    // two reads on adjacent edges
    @(negedge clk);
    cs_n = 1'b0; strb_n = 1'b0; wr_n = 1'b1; lane_n = 2'b00; bus_in = {2'b00, addrs[4]};
    @(negedge clk);
    bus_in = {2'b00, addrs[5]}; lane_n = 2'b10; oe_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; strb_n = 1'b1; lane_n = 2'b11; bus_in = 16'h0; #1;
    check("R9", 32'(bus_oe), 32'd3);
    check("R9", 32'(bus_out), 32'(ref_get(int'(addrs[4]))));
    @(negedge clk);
    #1;
    check("R9", 32'(bus_oe), 32'd1);
    check("R9", 32'(bus_out & 16'h00FF), 32'(ref_get(int'(addrs[5])) & 16'h00FF));
    @(negedge clk);
    idle(); #1;
    check("R9", 32'(bus_oe), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule